// File: doc/BRIEF.md
# Four-Point Inverse Transform Kernel

This block performs one of four one-dimensional inverse transforms on a group of four signed 16-bit coefficients, as used in the row and column passes of a block-based video decoder. A 2-bit kind select chooses between a cosine butterfly, an asymmetric sine transform, the same sine transform with its outputs in reverse order, and an identity scaling of roughly the square root of two. All products use 12-bit fixed-point constants with 32-bit accumulation. Every result is rounded and saturated back into the 16-bit signed range.

The datapath is combinational from the input ports to a single output register. A caller presents the four coefficients and the kind with `in_valid` high, and the four results appear on the next cycle with `out_valid` high. The results stay on the outputs until the next accepted group. Transposition, the second pass and pixel reconstruction belong to the surrounding logic.

Top module: `itx4_kernel`

## Requirements
- R1: While `rst` is high at a rising clock edge, the following cycle shows `out_valid` low and all four outputs equal to zero.
- R2: A group accepted with `in_valid` high at a rising edge produces its results and `out_valid` high after exactly that edge; an edge with `in_valid` low leaves `out_valid` low.
- R3: While `in_valid` is low, the four outputs keep their last values whatever `kind` and the coefficient inputs do.
- R4: Each 32-bit product-sum is narrowed by adding 2048, shifting right arithmetically by 12 (so negative halves round toward positive infinity), and clamping to the range -32768..32767.
- R5: With `kind` = 0 (cosine butterfly), the four intermediate terms are p = narrow((x0+x2)*2896), q = narrow((x0-x2)*2896), u = narrow(x1*3784 + x3*1567), w = narrow(x1*1567 - x3*3784).
- R6: With `kind` = 0, the outputs are y0 = p+u, y1 = q+w, y2 = q-w, y3 = p-u, each a 16-bit saturating add or subtract.
- R7: With `kind` = 1 (asymmetric sine), with A = x0*1321 + x2*2482 + x3*3344, B = x0*3344 - x2*1321 - x3*2482 and C = x1*3803, the outputs are y0 = narrow(A+C), y1 = narrow(B+C) and y3 = narrow(A+B-C).
- R8: With `kind` = 1, y2 = narrow((x0 - x2 + x3) * 3344), where the sum is formed at 32-bit width without intermediate clamping.
- R9: With `kind` = 2 (flipped sine), y0..y3 equal the `kind` = 1 results for the same inputs in reverse order (y0 gets the sine's fourth output, y3 its first).
- R10: With `kind` = 3 (identity), each lane computes h = clamp((2*x*13576 + 32768) >>> 16) and outputs the saturating sum x + h, independently of the other lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A coefficient group is presented this cycle |
| kind | input | 2 | Transform select: 0 cosine, 1 sine, 2 flipped sine, 3 identity |
| x0 | input | 16 | Coefficient 0, signed |
| x1 | input | 16 | Coefficient 1, signed |
| x2 | input | 16 | Coefficient 2, signed |
| x3 | input | 16 | Coefficient 3, signed |
| out_valid | output | 1 | Results from the previous accepted group are new this cycle |
| y0 | output | 16 | Result 0, signed |
| y1 | output | 16 | Result 1, signed |
| y2 | output | 16 | Result 2, signed |
| y3 | output | 16 | Result 3, signed |

## Verification
A lone DC coefficient shows whether the butterfly spreads it evenly to all four outputs, while a dense mixed-sign group tells a swapped constant or a swapped add and subtract apart in every kernel. The same groups run through kinds 1 and 2, so a wrong output order in the flipped variant shows at once, and a sparse group with only the first and last coefficient set isolates the sine's third output. Small negative inputs separate an arithmetic shift from a truncation toward zero, and full-scale positive and negative inputs drive both the narrowing clamp and the saturating adds into their limits.

// File: rtl/itx4_pkg.sv
package itx4_pkg;

    localparam int DW    = 16;            // sample width
    localparam int AW    = 32;            // accumulator width
    localparam int FRAC  = 12;            // fraction bits of the constants
    localparam int LANES = 4;

    localparam int SMAX  = (2 ** (DW - 1)) - 1;
    localparam int SMIN  = -(2 ** (DW - 1));
    localparam int RND   = 2 ** (FRAC - 1);
    localparam int HRND  = 2 ** (DW - 1);

    typedef logic signed [DW-1:0] samp_t;
    typedef logic signed [AW-1:0] acc_t;
    typedef logic signed [AW:0]   rnd_t;
    typedef logic signed [DW:0]   wide_t;
    typedef samp_t                quad_t [LANES];

    typedef enum logic [1:0] {
        KIND_COS   = 2'd0,
        KIND_SIN   = 2'd1,
        KIND_FLIP  = 2'd2,
        KIND_IDENT = 2'd3
    } kind_e;

    // cosine butterfly constants
    localparam acc_t K_HALF = 32'sd2896;
    localparam acc_t K_LO   = 32'sd1567;
    localparam acc_t K_HI   = 32'sd3784;
    // asymmetric sine constants
    localparam acc_t K_S0   = 32'sd1321;
    localparam acc_t K_S1   = 32'sd2482;
    localparam acc_t K_S2   = 32'sd3344;
    localparam acc_t K_S3   = 32'sd3803;
    // identity gain minus one, in high-multiply form
    localparam acc_t K_ID   = 32'sd13576;

    function automatic acc_t widen(input samp_t x);
        return acc_t'(x);
    endfunction

    function automatic samp_t clamp_rnd(input rnd_t s);
        if (s > rnd_t'(SMAX))      return samp_t'(SMAX);
        else if (s < rnd_t'(SMIN)) return samp_t'(SMIN);
        else                       return samp_t'(s);
    endfunction

    // round by adding half an LSB, arithmetic shift, clamp
    function automatic samp_t narrow(input acc_t v);
        rnd_t s;
        s = rnd_t'(v) + rnd_t'(RND);
        s = s >>> FRAC;
        return clamp_rnd(s);
    endfunction

    function automatic samp_t sat_add(input samp_t a, input samp_t b, input logic sub);
        wide_t s;
        s = sub ? (wide_t'(a) - wide_t'(b)) : (wide_t'(a) + wide_t'(b));
        if (s > wide_t'(SMAX))      return samp_t'(SMAX);
        else if (s < wide_t'(SMIN)) return samp_t'(SMIN);
        else                        return samp_t'(s);
    endfunction

    // doubled, rounded high half of x * K_ID
    function automatic samp_t dbl_high_mul(input samp_t x);
        rnd_t q;
        q = (rnd_t'(widen(x) * K_ID) <<< 1) + rnd_t'(HRND);
        q = q >>> DW;
        return clamp_rnd(q);
    endfunction

endpackage

// File: rtl/itx4_cos.sv
module itx4_cos
    import itx4_pkg::*;
(
    input  samp_t a [LANES],
    output samp_t o [LANES]
);
    samp_t p, q, u, w;

    always_comb begin
        p = narrow((widen(a[0]) + widen(a[2])) * K_HALF);
        q = narrow((widen(a[0]) - widen(a[2])) * K_HALF);
        u = narrow(widen(a[1]) * K_HI + widen(a[3]) * K_LO);
        w = narrow(widen(a[1]) * K_LO - widen(a[3]) * K_HI);
        o[0] = sat_add(p, u, 1'b0);
        o[1] = sat_add(q, w, 1'b0);
        o[2] = sat_add(q, w, 1'b1);
        o[3] = sat_add(p, u, 1'b1);
    end
endmodule

// File: rtl/itx4_sin.sv
module itx4_sin
    import itx4_pkg::*;
(
    input  samp_t a [LANES],
    output samp_t o [LANES]
);
    acc_t ta, tb, tc, td;

    always_comb begin
        ta = widen(a[0]) * K_S0 + widen(a[2]) * K_S1 + widen(a[3]) * K_S2;
        tb = widen(a[0]) * K_S2 - widen(a[2]) * K_S0 - widen(a[3]) * K_S1;
        tc = widen(a[1]) * K_S3;
        td = (widen(a[0]) - widen(a[2]) + widen(a[3])) * K_S2;
        o[0] = narrow(ta + tc);
        o[1] = narrow(tb + tc);
        o[2] = narrow(td);
        o[3] = narrow(ta + tb - tc);
    end
endmodule

// File: rtl/itx4_ident.sv
module itx4_ident
    import itx4_pkg::*;
(
    input  samp_t a [LANES],
    output samp_t o [LANES]
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign o[i] = sat_add(a[i], dbl_high_mul(a[i]), 1'b0);
    end
endmodule

// File: rtl/itx4_kernel.sv
module itx4_kernel
    import itx4_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  kind,
    input  logic [15:0] x0,
    input  logic [15:0] x1,
    input  logic [15:0] x2,
    input  logic [15:0] x3,
    output logic        out_valid,
    output logic [15:0] y0,
    output logic [15:0] y1,
    output logic [15:0] y2,
    output logic [15:0] y3
);
    samp_t src   [LANES];
    samp_t cos_o [LANES];
    samp_t sin_o [LANES];
    samp_t id_o  [LANES];
    samp_t pick  [LANES];
    samp_t held  [LANES];
    logic  vld_q;
    kind_e sel;

    assign src[0] = samp_t'(x0);
    assign src[1] = samp_t'(x1);
    assign src[2] = samp_t'(x2);
    assign src[3] = samp_t'(x3);
    assign sel    = kind_e'(kind);

    itx4_cos   u_cos   (.a(src), .o(cos_o));
    itx4_sin   u_sin   (.a(src), .o(sin_o));
    itx4_ident u_ident (.a(src), .o(id_o));

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            case (sel)
                KIND_COS:  pick[i] = cos_o[i];
                KIND_SIN:  pick[i] = sin_o[i];
                KIND_FLIP: pick[i] = sin_o[LANES-1-i];
                default:   pick[i] = id_o[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            for (int i = 0; i < LANES; i++) held[i] <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                for (int i = 0; i < LANES; i++) held[i] <= pick[i];
            end
        end
    end

    assign out_valid = vld_q;
    assign y0 = held[0];
    assign y1 = held[1];
    assign y2 = held[2];
    assign y3 = held[3];
endmodule

// File: rtl/itx4_chk.sv
module itx4_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  kind,
    input logic [15:0] x0,
    input logic [15:0] x1,
    input logic [15:0] x2,
    input logic [15:0] x3,
    input logic        out_valid,
    input logic [15:0] y0,
    input logic [15:0] y1,
    input logic [15:0] y2,
    input logic [15:0] y3
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && y0 == 16'd0 && y1 == 16'd0 && y2 == 16'd0 && y3 == 16'd0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(y0) && $stable(y1) && $stable(y2) && $stable(y3)));

    // even-only cosine input: mirrored outputs
    assert_cos_mirror_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == 2'd0 && x1 == 16'd0 && x3 == 16'd0) |=> (y0 == y3 && y1 == y2));

    // identity gain is positive: the sign of each lane survives
    assert_ident_sign_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == 2'd3) |=>
        (y0[15] == $past(x0[15]) && y1[15] == $past(x1[15]) &&
         y2[15] == $past(x2[15]) && y3[15] == $past(x3[15])));
endmodule

bind itx4_kernel itx4_chk u_itx4_chk (.*);

// File: tb/test_itx4_kernel.sv
`timescale 1ns/1ps
module test_itx4_kernel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [15:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
    logic        out_valid;
    logic [15:0] y0, y1, y2, y3;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    itx4_kernel i_itx4_kernel (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind),
        .x0(x0), .x1(x1), .x2(x2), .x3(x3),
        .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2), .y3(y3)
    );

    // ---------------- reference model ----------------
    function automatic longint clip(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint nrw(input longint v);
        return clip((v + 2048) >>> 12);
    endfunction

    function automatic void model(input int k, input longint a [4], output longint r [4]);
        longint p, q, u, w, ta, tb, tc, h;
        longint s [4];
        p  = nrw((a[0] + a[2]) * 2896);
        q  = nrw((a[0] - a[2]) * 2896);
        u  = nrw(a[1] * 3784 + a[3] * 1567);
        w  = nrw(a[1] * 1567 - a[3] * 3784);
        ta = a[0] * 1321 + a[2] * 2482 + a[3] * 3344;
        tb = a[0] * 3344 - a[2] * 1321 - a[3] * 2482;
        tc = a[1] * 3803;
        s[0] = nrw(ta + tc);
        s[1] = nrw(tb + tc);
        s[2] = nrw((a[0] - a[2] + a[3]) * 3344);
        s[3] = nrw(ta + tb - tc);
        case (k)
            0: begin
                r[0] = clip(p + u); r[1] = clip(q + w);
                r[2] = clip(q - w); r[3] = clip(p - u);
            end
            1: for (int i = 0; i < 4; i++) r[i] = s[i];
            2: for (int i = 0; i < 4; i++) r[i] = s[3 - i];
            default: for (int i = 0; i < 4; i++) begin
                h = clip((2 * a[i] * 13576 + 32768) >>> 16);
                r[i] = clip(a[i] + h);
            end
        endcase
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sv(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic run_group(input string req, input int k,
                             input int a0, input int a1, input int a2, input int a3);
        longint a [4];
        longint e [4];
        a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
        model(k, a, e);
        @(negedge clk);
        kind = 2'(k);
        x0 = 16'(a0); x1 = 16'(a1); x2 = 16'(a2); x3 = 16'(a3);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid", longint'(out_valid), 1);
        check(req, "y0", sv(y0), e[0]);
        check(req, "y1", sv(y1), e[1]);
        check(req, "y2", sv(y2), e[2]);
        check(req, "y3", sv(y3), e[3]);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_R1;
        repeat (3) @(negedge clk);
        check("R1", "out_valid", longint'(out_valid), 0);
        check("R1", "y0", sv(y0), 0);
        check("R1", "y3", sv(y3), 0);
        rst = 1'b0;
    endtask

    task automatic t_cosine_R5_R6;
        run_group("R5", 0, 64, 0, 0, 0);
        run_group("R6", 0, 50, -25, 15, -10);
        run_group("R6", 0, 0, 300, 0, -700);
    endtask

    task automatic t_rounding_R4;
        run_group("R4", 0, -1, 0, 0, 0);
        run_group("R4", 0, 1, 0, 0, 0);
        run_group("R4", 1, -3, 2, -1, 1);
    endtask

    task automatic t_saturation_R4;
        run_group("R4", 0, 32767, 32767, 32767, 0);
        run_group("R6", 0, -32768, -32768, 32767, 32767);
        run_group("R7", 1, 32767, 32767, -32768, 32767);
    endtask

    task automatic t_sine_R7_R8;
        run_group("R7", 1, 50, -25, 15, -10);
        run_group("R8", 1, 32, 0, 0, 16);
        run_group("R8", 1, 20000, 0, -20000, 20000);
    endtask

    task automatic t_flip_R9;
        run_group("R9", 2, 50, -25, 15, -10);
        run_group("R9", 2, 32, 0, 0, 16);
        run_group("R9", 2, -400, 900, 120, -5);
    endtask

    task automatic t_ident_R10;
        run_group("R10", 3, 100, -100, 1, -1);
        run_group("R10", 3, 32767, -32768, 27000, -27000);
    endtask

    task automatic t_hold_R3;
        logic [15:0] s0, s1, s2, s3;
        run_group("R3", 1, 77, -33, 12, 5);
        s0 = y0; s1 = y1; s2 = y2; s3 = y3;
        @(negedge clk);
        kind = 2'd3; x0 = 16'd999; x1 = 16'hF000; x2 = 16'd4; x3 = 16'd8;
        repeat (2) @(negedge clk);
        check("R2", "out_valid idle", longint'(out_valid), 0);
        check("R3", "y0 held", sv(y0), sv(s0));
        check("R3", "y1 held", sv(y1), sv(s1));
        check("R3", "y2 held", sv(y2), sv(s2));
        check("R3", "y3 held", sv(y3), sv(s3));
    endtask

    initial begin
        t_reset_R1();
        t_cosine_R5_R6();
        t_rounding_R4();
        t_saturation_R4();
        t_sine_R7_R8();
        t_flip_R9();
        t_ident_R10();
        t_hold_R3();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule